// File: doc/BRIEF.md
# Masked CAM with Validity States

This block is a parameterized content-addressable memory. Each entry stores a data word and a two-bit validity code. When a compare is triggered, a search key is checked against every entry at once. Only entries in the Valid state can hit. One clock later the block reports three things: whether any entry hit, whether more than one entry hit, and the index of the lowest-numbered hit.

Two mask registers shape the search. For each compare, one of them is chosen. Bit positions where the chosen mask is zero are left out of the compare. So the boundary between the key field and the associated-data field can sit at any bit position. After a hit, the unmasked (ignored) bits of the winning entry are returned as associated data.

Writes to an entry can also be gated by a chosen mask. In that case only the bit positions where the mask is one are updated.

Top module: `mcam_top`

## Requirements
- R1: The validity code `{skip, empty}` means: 2'b00 Valid, 2'b01 Empty, 2'b10 Skip, 2'b11 RAM. Only Valid entries can hit. An Empty, Skip or RAM entry whose word equals the key never raises `hit`.
- R2: After reset, every entry is Empty, both mask registers are all ones, and `hit`, `multi_hit`, `hit_addr` and `assoc_data` are zero.
- R3: After a compare, `hit` is 1 if at least one Valid entry matches on all compared bits. `hit_addr` is the lowest index among the matching entries, and 0 when nothing matches.
- R4: `multi_hit` is 1 exactly when two or more Valid entries match.
- R5: A bit position whose bit in the chosen compare mask is 0 is not compared. An all-zero mask makes every Valid entry match.
- R6: `assoc_data` equals the word of the reported entry ANDed with the inverse of the compare mask. It is zero when nothing hits.
- R7: When `wr_masked` is 1, a write changes only the bit positions where the mask chosen by `wr_msel` is 1. All other bits keep their old value. The validity code is always written.
- R8: Results appear one clock after the edge where `cmp_go` is sampled high. They hold unchanged until the next compare.
- R9: Mask register 0 and mask register 1 are loaded separately through `mask_ld`/`mask_lsel`. `cmp_msel` picks which of them is used for a compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry |
| wr_addr | input | AW | Entry index to write |
| wr_word | input | W | Word to store |
| wr_state | input | 2 | Validity code to store |
| wr_masked | input | 1 | Apply the write mask |
| wr_msel | input | 1 | Which mask gates the write |
| mask_ld | input | 1 | Load a mask register |
| mask_lsel | input | 1 | Which mask register to load |
| mask_val | input | W | Value loaded into the mask register |
| cmp_go | input | 1 | Trigger a compare |
| cmp_msel | input | 1 | Which mask the compare uses |
| cmp_key | input | W | Search key |
| hit | output | 1 | At least one Valid entry matched |
| multi_hit | output | 1 | Two or more Valid entries matched |
| hit_addr | output | AW | Lowest matching index |
| assoc_data | output | W | Uncompared bits of the reported entry |

## Verification
Assertions check the following on every cycle:
- `multi_hit` never appears without `hit`.
- Results stay frozen between compares.
- `assoc_data` never carries a compared bit.
- No hit is reported when the match vector was empty.

Only the bench scenarios can show the rest:
- Which entry wins when several match.
- That Empty, Skip and RAM entries stay silent even when their word equals the key.
- The reset values of the masks.
- That a masked write leaves the gated-off bits intact.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [1:0] {
        VS_VALID = 2'b00,
        VS_EMPTY = 2'b01,
        VS_SKIP  = 2'b10,
        VS_RAM   = 2'b11
    } vstate_e;

    localparam int unsigned NUM_MASKS = 2;

    function automatic logic is_live(vstate_e s);
        return s == VS_VALID;
    endfunction

    function automatic logic key_equal(logic [63:0] a, logic [63:0] b,
                                       logic [63:0] m);
        return ((a ^ b) & m) == '0;
    endfunction
endpackage

// File: rtl/cam_mask_bank.sv
module cam_mask_bank #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         ld_sel,
    input  logic [W-1:0] ld_val,
    input  logic         cmp_sel,
    input  logic         wr_sel,
    output logic [W-1:0] cmp_mask,
    output logic [W-1:0] wr_mask
);
    import cam_pkg::*;

    logic [W-1:0] mreg [NUM_MASKS];

    for (genvar g = 0; g < NUM_MASKS; g++) begin : g_mreg
        always_ff @(posedge clk) begin
            if (rst) begin
                mreg[g] <= '1;
            end else if (ld && (ld_sel == 1'(g))) begin
                mreg[g] <= ld_val;
            end
        end
    end

    assign cmp_mask = mreg[cmp_sel];
    assign wr_mask  = mreg[wr_sel];
endmodule

// File: rtl/cam_store.sv
module cam_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [W-1:0]          wr_word,
    input  cam_pkg::vstate_e      wr_state,
    input  logic                  wr_masked,
    input  logic [W-1:0]          wr_mask,
    output logic [W-1:0]          words  [DEPTH],
    output cam_pkg::vstate_e      states [DEPTH]
);
    import cam_pkg::*;

    logic [W-1:0] gate;
    assign gate = wr_masked ? wr_mask : '1;

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic sel;
        assign sel = wr_en && (wr_addr == AW'(e));
        always_ff @(posedge clk) begin
            if (rst) begin
                words[e]  <= '0;
                states[e] <= VS_EMPTY;
            end else if (sel) begin
                words[e]  <= (words[e] & ~gate) | (wr_word & gate);
                states[e] <= wr_state;
            end
        end
    end
endmodule

// File: rtl/cam_match.sv
module cam_match #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 64
) (
    input  logic [W-1:0]     words  [DEPTH],
    input  cam_pkg::vstate_e states [DEPTH],
    input  logic [W-1:0]     key,
    input  logic [W-1:0]     mask,
    output logic [DEPTH-1:0] lines
);
    import cam_pkg::*;

    for (genvar e = 0; e < DEPTH; e++) begin : g_line
        assign lines[e] = is_live(states[e]) &&
                          (((words[e] ^ key) & mask) == '0);
    end
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] lines,
    output logic             any,
    output logic             many,
    output logic [AW-1:0]    first
);
    always_comb begin
        any   = 1'b0;
        many  = 1'b0;
        first = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lines[i]) begin
                if (any) many = 1'b1;
                else     first = AW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcam_top.sv
module mcam_top #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_word,
    input  logic [1:0]    wr_state,
    input  logic          wr_masked,
    input  logic          wr_msel,
    input  logic          mask_ld,
    input  logic          mask_lsel,
    input  logic [W-1:0]  mask_val,
    input  logic          cmp_go,
    input  logic          cmp_msel,
    input  logic [W-1:0]  cmp_key,
    output logic          hit,
    output logic          multi_hit,
    output logic [AW-1:0] hit_addr,
    output logic [W-1:0]  assoc_data
);
    import cam_pkg::*;

    logic [W-1:0]     cmask, wmask;
    logic [W-1:0]     words  [DEPTH];
    vstate_e          states [DEPTH];
    logic [DEPTH-1:0] lines;
    logic             any, many;
    logic [AW-1:0]    first;

    cam_mask_bank #(.W(W)) u_masks (
        .clk(clk), .rst(rst), .ld(mask_ld), .ld_sel(mask_lsel),
        .ld_val(mask_val), .cmp_sel(cmp_msel), .wr_sel(wr_msel),
        .cmp_mask(cmask), .wr_mask(wmask)
    );

    cam_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_word(wr_word), .wr_state(vstate_e'(wr_state)),
        .wr_masked(wr_masked), .wr_mask(wmask),
        .words(words), .states(states)
    );

    cam_match #(.DEPTH(DEPTH), .W(W)) u_match (
        .words(words), .states(states), .key(cmp_key), .mask(cmask),
        .lines(lines)
    );

    cam_prio #(.DEPTH(DEPTH)) u_prio (
        .lines(lines), .any(any), .many(many), .first(first)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit        <= 1'b0;
            multi_hit  <= 1'b0;
            hit_addr   <= '0;
            assoc_data <= '0;
        end else if (cmp_go) begin
            hit        <= any;
            multi_hit  <= many;
            hit_addr   <= first;
            assoc_data <= any ? (words[first] & ~cmask) : '0;
        end
    end

    // R4: a multiple hit always implies a hit
    a_r4_multi_needs_hit: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> hit);

    // R8: results frozen between compares
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(cmp_go) |-> ($stable(hit) && $stable(multi_hit) &&
                            $stable(hit_addr) && $stable(assoc_data)));

    // R6: associated data never carries a compared bit
    a_r6_assoc_clean: assert property (@(posedge clk) disable iff (rst)
        $past(cmp_go) |-> ((assoc_data & $past(cmask)) == '0));

    // R3: no match lines means no hit
    a_r3_no_line_no_hit: assert property (@(posedge clk) disable iff (rst)
        ($past(cmp_go) && ($past(lines) == '0)) |-> !hit);
endmodule

// File: tb/sim_mcam_top.sv
module sim_mcam_top;
    localparam int DEPTH = 16;
    localparam int W     = 64;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, wr_masked, wr_msel;
    logic [AW-1:0] wr_addr;
    logic [W-1:0]  wr_word;
    logic [1:0]    wr_state;
    logic          mask_ld, mask_lsel;
    logic [W-1:0]  mask_val;
    logic          cmp_go, cmp_msel;
    logic [W-1:0]  cmp_key;
    logic          hit, multi_hit;
    logic [AW-1:0] hit_addr;
    logic [W-1:0]  assoc_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mcam_top #(.DEPTH(DEPTH), .W(W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_word(wr_word), .wr_state(wr_state), .wr_masked(wr_masked),
        .wr_msel(wr_msel), .mask_ld(mask_ld), .mask_lsel(mask_lsel),
        .mask_val(mask_val), .cmp_go(cmp_go), .cmp_msel(cmp_msel),
        .cmp_key(cmp_key), .hit(hit), .multi_hit(multi_hit),
        .hit_addr(hit_addr), .assoc_data(assoc_data)
    );

    // {msel, key, exp_hit, exp_multi, exp_addr, exp_assoc}
    localparam int VW = 1 + 64 + 1 + 1 + 4 + 64;
    localparam int NV = 9;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 64'h1111_1111_AAAA_0000, 1'b1, 1'b0, 4'd0, 64'h0},
        {1'b0, 64'h2222_2222_0000_BBBB, 1'b1, 1'b1, 4'd1, 64'h0},
        {1'b1, 64'h1111_1111_0000_0000, 1'b1, 1'b1, 4'd0, 64'h0000_0000_AAAA_0000},
        {1'b1, 64'h3333_3333_0000_0001, 1'b0, 1'b0, 4'd0, 64'h0},
        {1'b1, 64'h4444_4444_0000_0002, 1'b0, 1'b0, 4'd0, 64'h0},
        {1'b1, 64'h5555_5555_0000_0003, 1'b0, 1'b0, 4'd0, 64'h0},
        {1'b0, 64'h1111_1111_CCCC_CCCC, 1'b1, 1'b0, 4'd2, 64'h0},
        {1'b1, 64'h2222_2222_9999_9999, 1'b1, 1'b1, 4'd1, 64'h0000_0000_0000_BBBB},
        {1'b0, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0, 1'b0, 4'd0, 64'h0}
    };

    task automatic chk(string req, logic h, logic m, logic [AW-1:0] a,
                       logic [W-1:0] d);
        checks++;
        if (hit !== h || multi_hit !== m || hit_addr !== a || assoc_data !== d) begin
            errors++;
            $display("FAIL %s: got hit=%0b multi=%0b addr=%0d assoc=%h exp hit=%0b multi=%0b addr=%0d assoc=%h",
                     req, hit, multi_hit, hit_addr, assoc_data, h, m, a, d);
        end
    endtask

    task automatic wr(int a, logic [W-1:0] d, logic [1:0] s, logic msk, logic ms);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_word = d; wr_state = s;
        wr_masked = msk; wr_msel = ms;
        @(negedge clk);
        wr_en = 1'b0; wr_masked = 1'b0;
    endtask

    task automatic ldm(logic sel, logic [W-1:0] v);
        @(negedge clk);
        mask_ld = 1'b1; mask_lsel = sel; mask_val = v;
        @(negedge clk);
        mask_ld = 1'b0;
    endtask

    // compare: go sampled at one edge, results checked at the next negedge
    task automatic cmp(logic sel, logic [W-1:0] k);
        @(negedge clk);
        cmp_go = 1'b1; cmp_msel = sel; cmp_key = k;
        @(negedge clk);
        cmp_go = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_masked = 0; wr_msel = 0; wr_addr = '0;
        wr_word = '0; wr_state = 2'b01; mask_ld = 0; mask_lsel = 0;
        mask_val = '0; cmp_go = 0; cmp_msel = 0; cmp_key = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset outputs", 1'b0, 1'b0, '0, '0);

        // R2: all entries Empty after reset -> zero key finds nothing
        cmp(1'b0, 64'h0);
        chk("R2 entries empty", 1'b0, 1'b0, '0, '0);

        // R2/R9: mask1 resets to all ones, so bit 0 is compared
        wr(15, 64'h0, 2'b00, 1'b0, 1'b0);
        cmp(1'b1, 64'h1);
        chk("R2 mask1 all ones", 1'b0, 1'b0, '0, '0);
        cmp(1'b0, 64'h0);
        chk("R3 single hit at 15", 1'b1, 1'b0, 4'd15, '0);

        // populate
        wr(0, 64'h1111_1111_AAAA_0000, 2'b00, 1'b0, 1'b0);
        wr(1, 64'h2222_2222_0000_BBBB, 2'b00, 1'b0, 1'b0);
        wr(2, 64'h1111_1111_CCCC_CCCC, 2'b00, 1'b0, 1'b0);
        wr(3, 64'h3333_3333_0000_0001, 2'b01, 1'b0, 1'b0);
        wr(4, 64'h4444_4444_0000_0002, 2'b10, 1'b0, 1'b0);
        wr(5, 64'h5555_5555_0000_0003, 2'b11, 1'b0, 1'b0);
        wr(6, 64'h2222_2222_0000_BBBB, 2'b00, 1'b0, 1'b0);
        ldm(1'b1, 64'hFFFF_FFFF_0000_0000);

        // table: R1 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            cmp(v[134], v[133:70]);
            chk($sformatf("R1/R3/R4/R6 vec %0d", i), v[69], v[68], v[67:64], v[63:0]);
        end

        // R1: exact-word key on Skip entry, all bits compared
        cmp(1'b0, 64'h4444_4444_0000_0002);
        chk("R1 skip exact word", 1'b0, 1'b0, '0, '0);

        // R8: outputs hold while key changes without a trigger
        cmp(1'b0, 64'h1111_1111_CCCC_CCCC);
        @(negedge clk); cmp_key = 64'h2222_2222_0000_BBBB;
        @(negedge clk); @(negedge clk);
        chk("R8 hold", 1'b1, 1'b0, 4'd2, '0);

        // R8: results visible one clock after go, not before
        @(negedge clk);
        cmp_go = 1'b1; cmp_msel = 1'b0; cmp_key = 64'h1111_1111_AAAA_0000;
        chk("R8 before edge", 1'b1, 1'b0, 4'd2, '0);
        @(negedge clk); cmp_go = 1'b0;
        chk("R8 after edge", 1'b1, 1'b0, 4'd0, '0);

        // R5: all-zero mask matches every Valid entry
        ldm(1'b1, 64'h0);
        cmp(1'b1, 64'h9876_5432_1000_0000);
        chk("R5 zero mask", 1'b1, 1'b1, 4'd0, 64'h1111_1111_AAAA_0000);

        // R7: masked write updates only bits with mask 1
        ldm(1'b0, 64'h0000_0000_FFFF_FFFF);
        wr(0, 64'hFFFF_FFFF_1234_5678, 2'b00, 1'b1, 1'b0);
        ldm(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        cmp(1'b1, 64'h1111_1111_1234_5678);
        chk("R7 masked write", 1'b1, 1'b0, 4'd0, '0);
        cmp(1'b1, 64'hFFFF_FFFF_1234_5678);
        chk("R7 gated bits kept", 1'b0, 1'b0, '0, '0);

        // R9: mask0 still lower-only, picks entry 0 with upper as assoc
        cmp(1'b0, 64'h0000_0000_1234_5678);
        chk("R9 mask0 select", 1'b1, 1'b0, 4'd0, 64'h1111_1111_0000_0000);

        // R1: entry 15 set to RAM no longer hits
        wr(15, 64'h0, 2'b11, 1'b0, 1'b0);
        cmp(1'b1, 64'h0);
        chk("R1 ram entry", 1'b0, 1'b0, '0, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule